// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Engine

This block applies a two-dimensional forward discrete cosine transform to one 8x8 tile of signed pixels, using only integer arithmetic. A host loads the tile by pushing 64 pixels one at a time, with the first 8 pushes forming row 0. A single start strobe then runs the whole transform on one shared multiplier. The 64 coefficients are read back one per pop, starting at frequency (0,0) and continuing in row-major order.

All cosine constants are signed 8-bit values with 6 fractional bits, so 1.0 is held as 64. Each product is shifted right by 6 as soon as it is formed, which makes the results bit-exact against a simple integer model. An optional quantizing mode divides every coefficient by 8 with an arithmetic shift. It is selected when the transform starts.

Top module: `fdct8x8_engine`

## Requirements
- R1: When idle, each push stores (pixel << 6) at row idx/8, column idx%8, then advances the 6-bit push index idx. After the 64th push the index wraps to 0, so a 65th push overwrites row 0, column 0.
- R2: The cosine constant for sample n and frequency f is cos((2n+1)·f·π/16) scaled by 64 and truncated toward zero. At multiples m·π/16 for m=0..8 this gives magnitudes 64, 62, 59, 53, 45, 35, 24, 12 and 0.
- R3: For frequency pair (u,v), the row pass forms s[x] = Σj ((pixel[x][j]<<6)·c(j,v)) >>> 6 for every x.
- R4: The column pass forms r = Σx (s[x]·c(x,u)) >>> 6.
- R5: The coefficient is ((r·k) >>> 6) >>> 6, truncated to 16 signed bits and stored at row u, column v. k comes from normalisation factors that are 45 at index 0 and 64 elsewhere. This gives k=16 when u and v are both nonzero, k=7 when both are zero, and k=11 otherwise.
- R6: When quant_en is high at the accepted start, every stored coefficient is the R5 value shifted right arithmetically by 3.
- R7: busy rises in the cycle after an accepted start. It stays high for exactly 1088 cycles (8 frequency columns × (64 + 8×9) cycles), while all 64 coefficients are written.
- R8: While busy, push_valid, pop and start have no effect on the stored pixels, the push index, the pop index or the run length.
- R9: When a transform ends, the push index is 0. An accepted start sets the pop index to 0. Each idle pop advances it, and pop_data always shows the coefficient at the current pop index. After 64 pops the index wraps to 0.
- R10: After reset, busy is low and every coefficient, including pop_data, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Store push_pixel at the push index |
| push_pixel | input | PIX_W (8) | Signed pixel value |
| start | input | 1 | Start the transform (accepted when idle) |
| quant_en | input | 1 | Quantize the results of the run being started |
| pop | input | 1 | Advance the pop index |
| pop_data | output | COEF_W (16) | Signed coefficient at the pop index |
| busy | output | 1 | Transform in progress |

## Verification
The hardest situation to reach from the ports is a push, pop or start that arrives in the middle of a run. Its effect would show up only later, as a shifted pixel position in a later tile or a first pop that no longer reads frequency (0,0). The stimulus injects each of these strobes about a hundred cycles into a run. It then loads a fresh tile and pops a full block, so any slip in an index changes the compared coefficients. A short partial load before a run shows whether the push index clears at the end of the run. Random tiles from a fixed seed, together with flat extremes, an impulse and a checkerboard, test the arithmetic against the independent integer model, both with and without quantization.

// File: rtl/fdct_pkg.sv
// Shared types and constant functions for the 8x8 forward DCT engine.
// Assumes an 8-point transform; constants use 6 fractional bits.
package fdct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ROW   = 2'd1,
        ST_COL   = 2'd2,
        ST_SCALE = 2'd3
    } dct_state_e;

    // Magnitude of 64*cos(m*pi/16) truncated, for m in 0..8
    function automatic logic signed [7:0] cos_mag(input int m);
        case (m)
            0:       cos_mag = 8'sd64;
            1:       cos_mag = 8'sd62;
            2:       cos_mag = 8'sd59;
            3:       cos_mag = 8'sd53;
            4:       cos_mag = 8'sd45;
            5:       cos_mag = 8'sd35;
            6:       cos_mag = 8'sd24;
            7:       cos_mag = 8'sd12;
            default: cos_mag = 8'sd0;
        endcase
    endfunction

    // Signed Q6 value of cos((2n+1)*f*pi/16), folded by symmetry
    function automatic logic signed [7:0] cos_q6(input logic [2:0] n, input logic [2:0] f);
        int m;
        logic signed [7:0] mag;
        m = ((2 * int'(n) + 1) * int'(f)) % 32;
        if (m > 16) m = 32 - m;
        if (m > 8) begin
            mag    = cos_mag(16 - m);
            cos_q6 = -mag;
        end else begin
            cos_q6 = cos_mag(m);
        end
    endfunction

    // Combined normalisation factor from C(u) and C(v) in Q6
    function automatic logic signed [7:0] norm_k(input logic [2:0] u, input logic [2:0] v);
        int cu;
        int cv;
        int k;
        cu = (u == 3'd0) ? 45 : 64;
        cv = (v == 3'd0) ? 45 : 64;
        k  = (((16 * cu) >> 6) * cv) >> 6;
        norm_k = 8'(k);
    endfunction

endpackage

// File: rtl/fdct_cos_rom.sv
// Cosine constant lookup: returns the Q6 basis value for sample index
// and frequency index. Purely combinational; assumes 3-bit indices.
module fdct_cos_rom
    import fdct_pkg::*;
(
    input  logic [2:0]        smp_idx,
    input  logic [2:0]        frq_idx,
    output logic signed [7:0] coef
);

    // Fold the angle and look up the truncated magnitude
    always_comb begin
        coef = cos_q6(smp_idx, frq_idx);
    end

endmodule

// File: rtl/fdct_mac.sv
// Shared multiply/shift/accumulate unit. Each product is shifted right by
// FRAC (or 2*FRAC in scale mode) before it is added. `last` returns the
// accumulator to zero so the next sum starts clean.
module fdct_mac #(
    parameter int ACC_W = 32,
    parameter int OPB_W = 8,
    parameter int FRAC  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    last,
    input  logic                    scale_mode,
    input  logic signed [ACC_W-1:0] opa,
    input  logic signed [OPB_W-1:0] opb,
    output logic signed [ACC_W-1:0] term,
    output logic signed [ACC_W-1:0] sum
);

    localparam int PROD_W = ACC_W + OPB_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic signed [ACC_W-1:0]  acc;

    // Single multiplier with the fixed-point shift after every product
    always_comb begin
        prod    = PROD_W'(opa) * PROD_W'(opb);
        shifted = scale_mode ? (prod >>> (2 * FRAC)) : (prod >>> FRAC);
        term    = ACC_W'(shifted);
        sum     = acc + term;
    end

    // Running sum register, cleared on the last term of a sum
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (en)     acc <= last ? '0 : sum;
    end

endmodule

// File: rtl/fdct_ctrl.sv
// Sequencer for the transform. For each frequency column v it runs one row
// pass (8x8 MACs building s[0..7]). Then, for each u, it runs 8 column MACs
// and one scale cycle. Assumes start is ignored while busy.
module fdct_ctrl
    import fdct_pkg::*;
#(
    parameter int BLK = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       quant_en,
    output logic       busy,
    output dct_state_e state,
    output logic [2:0] idx_x,
    output logic [2:0] idx_j,
    output logic [2:0] idx_u,
    output logic [2:0] idx_v,
    output logic       quant_q,
    output logic       s_we,
    output logic       r_we,
    output logic       coef_we,
    output logic       done
);

    localparam int RUN_CYC = BLK * (BLK * BLK + BLK * (BLK + 1));
    localparam int CNT_W   = $clog2(RUN_CYC + 2);

    dct_state_e st;

    // Step through row, column and scale phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            idx_x   <= '0;
            idx_j   <= '0;
            idx_u   <= '0;
            idx_v   <= '0;
            quant_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st      <= ST_ROW;
                    idx_x   <= '0;
                    idx_j   <= '0;
                    idx_u   <= '0;
                    idx_v   <= '0;
                    quant_q <= quant_en;
                end
                ST_ROW: begin
                    idx_j <= idx_j + 3'd1;
                    if (idx_j == 3'd7) begin
                        idx_x <= idx_x + 3'd1;
                        if (idx_x == 3'd7) begin
                            st    <= ST_COL;
                            idx_u <= '0;
                        end
                    end
                end
                ST_COL: begin
                    idx_x <= idx_x + 3'd1;
                    if (idx_x == 3'd7) st <= ST_SCALE;
                end
                default: begin
                    if (idx_u == 3'd7) begin
                        if (idx_v == 3'd7) begin
                            st <= ST_IDLE;
                        end else begin
                            idx_v <= idx_v + 3'd1;
                            st    <= ST_ROW;
                        end
                    end else begin
                        idx_u <= idx_u + 3'd1;
                        st    <= ST_COL;
                    end
                end
            endcase
        end
    end

    // Decode strobes for the datapath
    always_comb begin
        state   = st;
        busy    = (st != ST_IDLE);
        s_we    = (st == ST_ROW) && (idx_j == 3'd7);
        r_we    = (st == ST_COL) && (idx_x == 3'd7);
        coef_we = (st == ST_SCALE);
        done    = (st == ST_SCALE) && (idx_u == 3'd7) && (idx_v == 3'd7);
    end

    // Checker counter: busy cycles of the current run
    logic [CNT_W-1:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_cyc <= '0;
        else if (busy)  busy_cyc <= busy_cyc + 1'b1;
        else            busy_cyc <= '0;
    end

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> busy);

    a_r7_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cyc == CNT_W'(RUN_CYC)));

    a_r3_row_to_col: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ROW && idx_j == 3'd7 && idx_x == 3'd7) |=> (st == ST_COL && idx_x == 3'd0));

    a_r4_col_to_scale: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COL && idx_x == 3'd7) |=> (st == ST_SCALE));

endmodule

// File: rtl/fdct8x8_engine.sv
// Top of the 8x8 fixed-point forward DCT. Holds the pixel store, the row
// sums s[0..7], the column sum r and the coefficient store. Operands for
// the single shared multiplier are selected by phase. Assumes one pixel
// per push and one coefficient per pop, both only while idle.
module fdct8x8_engine
    import fdct_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int ACC_W  = 32,
    parameter int COEF_W = 16,
    parameter int FRAC   = 6,
    parameter int QSHIFT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_valid,
    input  logic signed [PIX_W-1:0]  push_pixel,
    input  logic                     start,
    input  logic                     quant_en,
    input  logic                     pop,
    output logic signed [COEF_W-1:0] pop_data,
    output logic                     busy
);

    localparam int BLK   = 8;
    localparam int CELLS = BLK * BLK;
    localparam int AW    = $clog2(CELLS);
    localparam int IN_W  = PIX_W + FRAC;
    localparam int OPB_W = 8;

    dct_state_e state;
    logic [2:0] idx_x, idx_j, idx_u, idx_v;
    logic       quant_q, s_we, r_we, coef_we, done;

    logic signed [IN_W-1:0]   pix_mem [CELLS];
    logic signed [ACC_W-1:0]  s_reg   [BLK];
    logic signed [ACC_W-1:0]  r_reg;
    logic signed [COEF_W-1:0] coef_mem [CELLS];
    logic [AW-1:0]            push_idx;
    logic [AW-1:0]            pop_idx;

    logic [2:0]               rom_smp, rom_frq;
    logic signed [7:0]        rom_coef;
    logic signed [ACC_W-1:0]  opa, mac_term, mac_sum;
    logic signed [OPB_W-1:0]  opb;
    logic                     mac_en, mac_last, scale_mode;
    logic signed [COEF_W-1:0] coef_raw, coef_fin;

    fdct_ctrl #(.BLK(BLK)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .quant_en (quant_en),
        .busy     (busy),
        .state    (state),
        .idx_x    (idx_x),
        .idx_j    (idx_j),
        .idx_u    (idx_u),
        .idx_v    (idx_v),
        .quant_q  (quant_q),
        .s_we     (s_we),
        .r_we     (r_we),
        .coef_we  (coef_we),
        .done     (done)
    );

    fdct_cos_rom u_rom (
        .smp_idx (rom_smp),
        .frq_idx (rom_frq),
        .coef    (rom_coef)
    );

    fdct_mac #(.ACC_W(ACC_W), .OPB_W(OPB_W), .FRAC(FRAC)) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (mac_en),
        .last       (mac_last),
        .scale_mode (scale_mode),
        .opa        (opa),
        .opb        (opb),
        .term       (mac_term),
        .sum        (mac_sum)
    );

    // Pick ROM indices and multiplier operands for the current phase
    always_comb begin
        rom_smp    = (state == ST_ROW) ? idx_j : idx_x;
        rom_frq    = (state == ST_ROW) ? idx_v : idx_u;
        mac_en     = (state == ST_ROW) || (state == ST_COL);
        mac_last   = s_we || r_we;
        scale_mode = (state == ST_SCALE);
        case (state)
            ST_ROW:   opa = ACC_W'(pix_mem[{idx_x, idx_j}]);
            ST_COL:   opa = s_reg[idx_x];
            ST_SCALE: opa = r_reg;
            default:  opa = '0;
        endcase
        opb = (state == ST_SCALE) ? norm_k(idx_u, idx_v) : rom_coef;
    end

    // Truncate the scaled sum and optionally quantize
    always_comb begin
        coef_raw = COEF_W'(mac_term);
        coef_fin = quant_q ? (coef_raw >>> QSHIFT) : coef_raw;
    end

    // Pixel store: pre-shifted sample written at the push index when idle
    always_ff @(posedge clk) begin
        if (push_valid && !busy) pix_mem[push_idx] <= IN_W'(push_pixel) <<< FRAC;
    end

    // Push index: advances on idle pushes, cleared at the end of a run
    always_ff @(posedge clk) begin
        if (!rst_n)                   push_idx <= '0;
        else if (done)                push_idx <= '0;
        else if (push_valid && !busy) push_idx <= push_idx + 1'b1;
    end

    // Row-pass results s[x] and column-pass result r
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_reg <= '0;
            for (int i = 0; i < BLK; i++) s_reg[i] <= '0;
        end else begin
            if (s_we) s_reg[idx_x] <= mac_sum;
            if (r_we) r_reg        <= mac_sum;
        end
    end

    // Coefficient store written at row u, column v
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) coef_mem[i] <= '0;
        end else if (coef_we) begin
            coef_mem[{idx_u, idx_v}] <= coef_fin;
        end
    end

    // Pop index: cleared by an accepted start, advanced by idle pops
    always_ff @(posedge clk) begin
        if (!rst_n)              pop_idx <= '0;
        else if (start && !busy) pop_idx <= '0;
        else if (pop && !busy)   pop_idx <= pop_idx + 1'b1;
    end

    // Present the coefficient at the pop index
    always_comb begin
        pop_data = coef_mem[pop_idx];
    end

    a_r1_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && push_valid && push_idx == AW'(CELLS - 1)) |=> (push_idx == '0));

    a_r8_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && push_valid && !done) |=> $stable(push_idx));

    a_r8_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pop) |=> $stable(pop_idx));

    a_r9_push_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (push_idx == '0 && !busy));

    a_r9_pop_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (pop_idx == '0));

endmodule

// File: tb/tb_fdct8x8_engine.sv
module tb_fdct8x8_engine;

    localparam int RUN_CYC = 1088;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               push_valid;
    logic signed [7:0]  push_pixel;
    logic               start;
    logic               quant_en;
    logic               pop;
    logic signed [15:0] pop_data;
    logic               busy;

    int errors = 0;
    int checks = 0;
    int blk [64];
    int wr_ptr = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fdct8x8_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_pixel (push_pixel),
        .start      (start),
        .quant_en   (quant_en),
        .pop        (pop),
        .pop_data   (pop_data),
        .busy       (busy)
    );

    function automatic int ref_cos(int n, int f);
        real a;
        a = 64.0 * $cos((2.0 * n + 1.0) * f * 3.14159265358979 / 16.0);
        return $rtoi(a);
    endfunction

    function automatic int ref_coef(int u, int v, bit q);
        longint s [8];
        longint r;
        longint val;
        int cu;
        int cv;
        int k;
        shortint c16;
        for (int x = 0; x < 8; x++) begin
            s[x] = 0;
            for (int j = 0; j < 8; j++)
                s[x] += ((longint'(blk[x*8+j]) <<< 6) * ref_cos(j, v)) >>> 6;
        end
        r = 0;
        for (int x = 0; x < 8; x++) r += (s[x] * ref_cos(x, u)) >>> 6;
        cu  = (u == 0) ? 45 : 64;
        cv  = (v == 0) ? 45 : 64;
        k   = (((16 * cu) >> 6) * cv) >> 6;
        val = ((r * k) >>> 6) >>> 6;
        c16 = shortint'(val);
        if (q) c16 = c16 >>> 3;
        return int'(c16);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_one(int p);
        push_valid = 1'b1;
        push_pixel = 8'(p);
        @(negedge clk);
        push_valid = 1'b0;
        blk[wr_ptr] = p;
        wr_ptr = (wr_ptr + 1) % 64;
    endtask

    task automatic push_block();
        for (int i = 0; i < 64; i++) push_one(blk[i]);
    endtask

    // inj: 0 none, 1 push, 2 pop, 3 start during the run
    task automatic run_dct(bit q, int inj);
        int cnt;
        quant_en = q;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        quant_en = 1'b0;
        cnt = 0;
        while (busy && cnt < 5000) begin
            cnt++;
            if (cnt == 100) begin
                if (inj == 1) begin push_valid = 1'b1; push_pixel = 8'sd55; end
                if (inj == 2) pop = 1'b1;
                if (inj == 3) start = 1'b1;
            end
            if (cnt == 101) begin
                push_valid = 1'b0;
                pop = 1'b0;
                start = 1'b0;
            end
            @(negedge clk);
        end
        chk("R7 busy length", cnt, RUN_CYC);
        wr_ptr = 0;
    endtask

    task automatic read_block(string req, bit q);
        for (int i = 0; i < 64; i++) begin
            chk(req, int'(pop_data), ref_coef(i / 8, i % 8, q));
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
        end
    endtask

    task automatic full_case(string req, bit q);
        push_block();
        run_dct(q, 0);
        read_block(req, q);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        rst_n = 1'b0;
        push_valid = 1'b0;
        push_pixel = '0;
        start = 1'b0;
        quant_en = 1'b0;
        pop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 busy after reset", int'(busy), 0);
        chk("R10 pop_data after reset", int'(pop_data), 0);

        // R3 R4 R5: flat blocks at the extremes
        for (int i = 0; i < 64; i++) blk[i] = 0;
        full_case("R5 zero block", 0);
        for (int i = 0; i < 64; i++) blk[i] = 127;
        full_case("R5 flat max", 0);
        for (int i = 0; i < 64; i++) blk[i] = -128;
        full_case("R5 flat min", 0);

        // R2: single impulse exercises one basis row per frequency
        for (int i = 0; i < 64; i++) blk[i] = 0;
        blk[9] = 100;
        full_case("R2 impulse", 0);

        // R3 R4: checkerboard and ramp
        for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 == 1) ? 127 : -128;
        full_case("R4 checkerboard", 0);
        for (int i = 0; i < 64; i++) blk[i] = i * 4 - 128;
        full_case("R3 ramp", 0);

        // R3 R4 R5: random tiles
        for (int t = 0; t < 5; t++) begin
            for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
            full_case("R5 random", 0);
        end

        // R6: quantized runs
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
            full_case("R6 quantized", 1);
        end

        // R9: pop index wraps after 64 pops back to coefficient (0,0)
        chk("R9 pop wrap", int'(pop_data), ref_coef(0, 0, 1));

        // R1: a 65th push overwrites row 0, column 0
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        push_block();
        push_one(-77);
        run_dct(0, 0);
        read_block("R1 push wrap", 0);

        // R8: push during a run is ignored
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        push_block();
        run_dct(0, 1);
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        full_case("R8 push while busy", 0);

        // R8: pop during a run is ignored; the first pop still reads (0,0)
        push_block();
        run_dct(0, 2);
        read_block("R8 pop while busy", 0);

        // R8: start during a run is ignored (run length checked inside run_dct)
        push_block();
        run_dct(0, 3);
        chk("R8 no restart", int'(busy), 0);
        read_block("R8 start while busy", 0);

        // R9: push index clears at the end of a run after a partial load
        for (int i = 0; i < 10; i++) push_one(int'($urandom_range(255)) - 128);
        run_dct(0, 0);
        read_block("R9 partial load", 0);
        for (int i = 0; i < 64; i++) blk[i] = int'($urandom_range(255)) - 128;
        full_case("R9 index reset", 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule